// File: doc/BRIEF.md
# Video Blanking Interval Generator

This block produces the horizontal and vertical timing events of a video output from the system clock. Two free-running counters each cover one period: a horizontal one of H clocks and a vertical one of V clocks. Each period is split at its midpoint. The horizontal counter gives a blank-start strobe at the boundary and a blank-end strobe at the midpoint. The vertical counter gives a blank-start strobe at the boundary and a blank-end strobe at the midpoint, the latter only while the in-blank state is held. The interlace field bit flips at every vertical blank end.

The period lengths come in as port values: two horizontal lengths, one for a 50 Hz raster and one for a 60 Hz raster, and four vertical lengths for every pairing of rate and scan type. Two select inputs choose among them. A chosen length is taken up at a period boundary, so a running period is never cut short.

A status word holds sticky flags for the two blank-end events and the field bit. A write of ones clears those flags and re-arms their interrupts. An armed event whose mask bit is clear raises a one-cycle display interrupt. Vertical blank start and end also pulse two lines of a system interrupt vector.

Top module: `blank_timing_gen`

## Requirements
- R1: `hblank_start` is high while the horizontal count is 0. This is the first cycle after reset, and then the first cycle of every horizontal period of H clocks.
- R2: `hblank_end` is high exactly floor(H/2) cycles after each `hblank_start`, where H is the length of that period.
- R3: `vblank_start` is high in the first cycle after reset and then once every V clocks, where V is the length of the vertical period then running.
- R4: `vblank_end` is high floor(V/2) cycles after `vblank_start`, and only while `in_vblank` is high. `in_vblank` goes high the cycle after `vblank_start` and low the cycle after `vblank_end`.
- R5: `field` (also status bit 13) is 0 after reset and flips in the cycle after each `vblank_end`.
- R6: Status bit 2 is set the cycle after `hblank_end`, and status bit 3 the cycle after `vblank_end`. Both stay set until cleared. Every status bit other than 2, 3 and 13 reads 0.
- R7: A cycle with `status_wr` high and `status_wdata[2]` (or `[3]`) at 1 clears status bit 2 (or 3) and re-arms its interrupt. If the matching event occurs in that same cycle, the event takes precedence.
- R8: `disp_irq` pulses for one cycle, the cycle after `hblank_end`, when the horizontal event is armed and `irq_mask[10]` is 0. It does the same after `vblank_end` when the vertical event is armed and `irq_mask[11]` is 0. Either event disarms its own interrupt, whatever the mask.
- R9: `sys_irq[2]` pulses the cycle after `vblank_start`, and `sys_irq[3]` the cycle after `vblank_end`. `sys_irq[1:0]` stay 0.
- R10: The horizontal length is `h_len_50` when `sel_50hz` is 1 and `h_len_60` otherwise. The vertical length is chosen from `v_len_50i/50p/60i/60p` by `sel_50hz` and `sel_interlace`. The value sampled at reset, or at the clock edge that ends a period, sets the length of the next period. Lengths must satisfy H ≥ 2 and V ≥ 4.
- R11: After a synchronous reset (`rst_n` low), the status word is 0, `disp_irq`, `sys_irq` and `in_vblank` are 0, and both interrupts are armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sel_50hz | input | 1 | 1 selects the 50 Hz period set |
| sel_interlace | input | 1 | 1 selects the interlaced vertical length |
| h_len_50 | input | HW | Horizontal period in clocks, 50 Hz |
| h_len_60 | input | HW | Horizontal period in clocks, 60 Hz |
| v_len_50i | input | VW | Vertical period, 50 Hz interlaced |
| v_len_50p | input | VW | Vertical period, 50 Hz progressive |
| v_len_60i | input | VW | Vertical period, 60 Hz interlaced |
| v_len_60p | input | VW | Vertical period, 60 Hz progressive |
| status_wr | input | 1 | Status clear write strobe |
| status_wdata | input | 2 (bits 3:2) | Write-one-to-clear bits for status bits 3 and 2 |
| irq_mask | input | 2 (bits 11:10) | Mask bits: 10 horizontal end, 11 vertical end |
| hblank_start | output | 1 | Horizontal blank start strobe |
| hblank_end | output | 1 | Horizontal blank end strobe |
| vblank_start | output | 1 | Vertical blank start strobe |
| vblank_end | output | 1 | Vertical blank end strobe |
| in_vblank | output | 1 | Vertical blank state |
| field | output | 1 | Interlace field bit |
| status | output | 16 | Status word: bit 2 h-end, bit 3 v-end, bit 13 field |
| disp_irq | output | 1 | Display interrupt pulse |
| sys_irq | output | 4 | System interrupt pulses: bit 2 v-start, bit 3 v-end |

## Verification
The hardest case to reach from the ports is a status clear that lands in the exact cycle of the event it clears. A close second is a period length change sampled in the exact cycle that ends a period. The stimulus uses very short horizontal periods (2 to 12 clocks) and vertical periods of a few dozen clocks. It issues clear writes on random cycles with random bit patterns and redraws the length and select inputs often. As a result, clear-versus-event collisions, arming with the mask set, and boundary-cycle length changes each occur many times. A cycle-accurate reference model in the bench checks every output on every cycle, and directed resets in the middle of the run confirm the reset state.

// File: rtl/blank_timing_pkg.sv
// Package: shared bit positions and sizes for the blanking interval generator.
// Assumes a 16-bit status word and a 4-line system interrupt vector.
package blank_timing_pkg;
    localparam int ST_W         = 16;
    localparam int ST_HEND_BIT  = 2;
    localparam int ST_VEND_BIT  = 3;
    localparam int ST_FIELD_BIT = 13;
    localparam int MSK_HEND_BIT = 10;
    localparam int MSK_VEND_BIT = 11;
    localparam int SYS_IRQ_W    = 4;
    localparam int SYS_VSTART   = 2;
    localparam int SYS_VEND     = 3;

    // Strobes of one cycle, passed from the timing logic to the status logic.
    typedef struct packed {
        logic h_end;
        logic v_start;
        logic v_end;
    } blank_evt_t;
endpackage

// File: rtl/btg_period_sel.sv
// Module: picks the horizontal and vertical period lengths from the rate and
// scan selects. Purely combinational; the counters sample the result.
module btg_period_sel #(
    parameter int HW = 16,
    parameter int VW = 24
) (
    input  logic          sel_50hz,
    input  logic          sel_interlace,
    input  logic [HW-1:0] h_len_50,
    input  logic [HW-1:0] h_len_60,
    input  logic [VW-1:0] v_len_50i,
    input  logic [VW-1:0] v_len_50p,
    input  logic [VW-1:0] v_len_60i,
    input  logic [VW-1:0] v_len_60p,
    output logic [HW-1:0] h_len_sel,
    output logic [VW-1:0] v_len_sel
);
    // Horizontal length depends on the rate only.
    always_comb h_len_sel = sel_50hz ? h_len_50 : h_len_60;

    // Vertical length depends on rate and scan type.
    always_comb begin
        unique case ({sel_50hz, sel_interlace})
            2'b11:   v_len_sel = v_len_50i;
            2'b10:   v_len_sel = v_len_50p;
            2'b01:   v_len_sel = v_len_60i;
            default: v_len_sel = v_len_60p;
        endcase
    end
endmodule

// File: rtl/btg_span_counter.sv
// Module: counts clocks 0..LEN-1 and flags the period start (count 0) and the
// midpoint (count LEN/2, rounded down). LEN is sampled in reset and at the
// edge that ends a period. Assumes LEN >= 2.
module btg_span_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] len_next,
    output logic         at_start,
    output logic         at_mid
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt_q;
    logic [W-1:0] len_q;
    logic         wrap;

    // The period ends on its last count.
    always_comb wrap = (cnt_q == len_q - ONE);

    // Advance the count; take up a new length at the period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            len_q <= len_next;
        end else if (wrap) begin
            cnt_q <= '0;
            len_q <= len_next;
        end else begin
            cnt_q <= cnt_q + ONE;
        end
    end

    // Decode the two event positions.
    always_comb begin
        at_start = (cnt_q == '0);
        at_mid   = (cnt_q == (len_q >> 1));
    end
endmodule

// File: rtl/btg_vblank_state.sv
// Module: holds the in-blank state and the interlace field bit. The midpoint
// counts as vertical blank end only while in blank.
module btg_vblank_state (
    input  logic clk,
    input  logic rst_n,
    input  logic v_at_start,
    input  logic v_at_mid,
    output logic v_end,
    output logic in_vblank,
    output logic field
);
    // Qualify the midpoint with the blank state.
    always_comb v_end = v_at_mid & in_vblank;

    // Set in blank at start, clear at end.
    always_ff @(posedge clk) begin
        if (!rst_n)          in_vblank <= 1'b0;
        else if (v_at_start) in_vblank <= 1'b1;
        else if (v_end)      in_vblank <= 1'b0;
    end

    // Flip the field at every vertical blank end.
    always_ff @(posedge clk) begin
        if (!rst_n)     field <= 1'b0;
        else if (v_end) field <= ~field;
    end
endmodule

// File: rtl/btg_status_ctl.sv
// Module: sticky event flags, per-event interrupt arming, the masked display
// interrupt and the system interrupt pulses. An event wins over a clear that
// lands in the same cycle.
module btg_status_ctl
    import blank_timing_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  blank_evt_t                evt,
    input  logic                      field,
    input  logic                      status_wr,
    input  logic [ST_VEND_BIT:ST_HEND_BIT]   status_wdata,
    input  logic [MSK_VEND_BIT:MSK_HEND_BIT] irq_mask,
    output logic [ST_W-1:0]           status,
    output logic                      disp_irq,
    output logic [SYS_IRQ_W-1:0]      sys_irq
);
    logic flag_h_q, flag_v_q;
    logic arm_h_q, arm_v_q;
    logic clr_h, clr_v;
    logic [SYS_IRQ_W-1:0] sys_d;

    // Decode the write-one-to-clear requests.
    always_comb begin
        clr_h = status_wr & status_wdata[ST_HEND_BIT];
        clr_v = status_wr & status_wdata[ST_VEND_BIT];
    end

    // Horizontal flag and arm: the event sets the flag and disarms; a clear re-arms.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_h_q <= 1'b0;
            arm_h_q  <= 1'b1;
        end else if (evt.h_end) begin
            flag_h_q <= 1'b1;
            arm_h_q  <= 1'b0;
        end else if (clr_h) begin
            flag_h_q <= 1'b0;
            arm_h_q  <= 1'b1;
        end
    end

    // Vertical flag and arm, same rules.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_v_q <= 1'b0;
            arm_v_q  <= 1'b1;
        end else if (evt.v_end) begin
            flag_v_q <= 1'b1;
            arm_v_q  <= 1'b0;
        end else if (clr_v) begin
            flag_v_q <= 1'b0;
            arm_v_q  <= 1'b1;
        end
    end

    // Display interrupt: an armed event with its mask bit clear.
    always_ff @(posedge clk) begin
        if (!rst_n) disp_irq <= 1'b0;
        else        disp_irq <= (evt.h_end & arm_h_q & ~irq_mask[MSK_HEND_BIT])
                              | (evt.v_end & arm_v_q & ~irq_mask[MSK_VEND_BIT]);
    end

    // Route the vertical events onto their system interrupt lines.
    for (genvar i = 0; i < SYS_IRQ_W; i++) begin : g_sys
        if (i == SYS_VSTART) begin : g_vs
            assign sys_d[i] = evt.v_start;
        end else if (i == SYS_VEND) begin : g_ve
            assign sys_d[i] = evt.v_end;
        end else begin : g_idle
            assign sys_d[i] = 1'b0;
        end
    end

    // Register the system interrupt pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) sys_irq <= '0;
        else        sys_irq <= sys_d;
    end

    // Assemble the status word.
    always_comb begin
        status               = '0;
        status[ST_HEND_BIT]  = flag_h_q;
        status[ST_VEND_BIT]  = flag_v_q;
        status[ST_FIELD_BIT] = field;
    end
endmodule

// File: rtl/blank_timing_gen.sv
// Module: top of the blanking interval generator. Chooses the period lengths,
// runs the horizontal and vertical counters, tracks blank state and field, and
// drives the status word and interrupts. Assumes H >= 2 and V >= 4.
module blank_timing_gen
    import blank_timing_pkg::*;
#(
    parameter int HW = 16,
    parameter int VW = 24
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sel_50hz,
    input  logic                      sel_interlace,
    input  logic [HW-1:0]             h_len_50,
    input  logic [HW-1:0]             h_len_60,
    input  logic [VW-1:0]             v_len_50i,
    input  logic [VW-1:0]             v_len_50p,
    input  logic [VW-1:0]             v_len_60i,
    input  logic [VW-1:0]             v_len_60p,
    input  logic                      status_wr,
    input  logic [ST_VEND_BIT:ST_HEND_BIT]   status_wdata,
    input  logic [MSK_VEND_BIT:MSK_HEND_BIT] irq_mask,
    output logic                      hblank_start,
    output logic                      hblank_end,
    output logic                      vblank_start,
    output logic                      vblank_end,
    output logic                      in_vblank,
    output logic                      field,
    output logic [ST_W-1:0]           status,
    output logic                      disp_irq,
    output logic [SYS_IRQ_W-1:0]      sys_irq
);
    logic [HW-1:0] h_len_sel;
    logic [VW-1:0] v_len_sel;
    logic          v_at_mid;
    blank_evt_t    evt;

    btg_period_sel #(.HW(HW), .VW(VW)) u_sel (
        .sel_50hz      (sel_50hz),
        .sel_interlace (sel_interlace),
        .h_len_50      (h_len_50),
        .h_len_60      (h_len_60),
        .v_len_50i     (v_len_50i),
        .v_len_50p     (v_len_50p),
        .v_len_60i     (v_len_60i),
        .v_len_60p     (v_len_60p),
        .h_len_sel     (h_len_sel),
        .v_len_sel     (v_len_sel)
    );

    btg_span_counter #(.W(HW)) u_hcnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .len_next (h_len_sel),
        .at_start (hblank_start),
        .at_mid   (hblank_end)
    );

    btg_span_counter #(.W(VW)) u_vcnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .len_next (v_len_sel),
        .at_start (vblank_start),
        .at_mid   (v_at_mid)
    );

    btg_vblank_state u_vstate (
        .clk        (clk),
        .rst_n      (rst_n),
        .v_at_start (vblank_start),
        .v_at_mid   (v_at_mid),
        .v_end      (vblank_end),
        .in_vblank  (in_vblank),
        .field      (field)
    );

    // Bundle the strobes for the status logic.
    always_comb begin
        evt.h_end   = hblank_end;
        evt.v_start = vblank_start;
        evt.v_end   = vblank_end;
    end

    btg_status_ctl u_stat (
        .clk          (clk),
        .rst_n        (rst_n),
        .evt          (evt),
        .field        (field),
        .status_wr    (status_wr),
        .status_wdata (status_wdata),
        .irq_mask     (irq_mask),
        .status       (status),
        .disp_irq     (disp_irq),
        .sys_irq      (sys_irq)
    );
endmodule

// File: rtl/btg_checker.sv
// Checker: temporal properties of the blanking generator, bound to the top.
module btg_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        hblank_start,
    input logic        hblank_end,
    input logic        vblank_start,
    input logic        vblank_end,
    input logic        in_vblank,
    input logic        field,
    input logic [15:0] status,
    input logic        disp_irq,
    input logic [3:0]  sys_irq
);
    // R2: start and midpoint never coincide when H >= 2.
    assert_h_events_apart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(hblank_start && hblank_end));

    // R4: the blank state is low when a new vertical period starts.
    assert_vstart_outside_blank_R4: assert property (@(posedge clk) disable iff (!rst_n)
        vblank_start |-> !in_vblank);

    // R4: the end strobe only appears inside blank.
    assert_vend_in_blank_R4: assert property (@(posedge clk) disable iff (!rst_n)
        vblank_end |-> in_vblank);

    // R5: field flips after each vertical blank end.
    assert_field_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
        vblank_end |=> (field != $past(field)));

    // R5: status bit 13 mirrors the field.
    assert_field_mirror_R5: assert property (@(posedge clk) disable iff (!rst_n)
        status[13] == field);

    // R6: flags are set the cycle after their events.
    assert_hflag_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hblank_end |=> status[2]);
    assert_vflag_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        vblank_end |=> status[3]);

    // R8: a display interrupt always follows an end event.
    assert_disp_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        disp_irq |-> $past(hblank_end || vblank_end));

    // R9: system interrupt lines follow the vertical events.
    assert_sys_vstart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        vblank_start |=> sys_irq[2]);
    assert_sys_vend_R9: assert property (@(posedge clk) disable iff (!rst_n)
        vblank_end |=> sys_irq[3]);
    assert_sys_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sys_irq[1:0] == 2'b00);

    // R11: state after a reset cycle.
    assert_reset_state_R11: assert property (@(posedge clk)
        $past(!rst_n) |-> (status == 16'h0 && !disp_irq && sys_irq == 4'h0 && !in_vblank));
endmodule

bind blank_timing_gen btg_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .hblank_start (hblank_start),
    .hblank_end   (hblank_end),
    .vblank_start (vblank_start),
    .vblank_end   (vblank_end),
    .in_vblank    (in_vblank),
    .field        (field),
    .status       (status),
    .disp_irq     (disp_irq),
    .sys_irq      (sys_irq)
);

// File: tb/blank_timing_gen_test.sv
// Bench: random and directed stimulus against a cycle-level reference model.
module blank_timing_gen_test;
    localparam int HW = 16;
    localparam int VW = 24;
    localparam int STEPS = 20000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sel_50hz = 1'b0, sel_interlace = 1'b0;
    logic [HW-1:0] h_len_50 = 16'd6, h_len_60 = 16'd5;
    logic [VW-1:0] v_len_50i = 24'd20, v_len_50p = 24'd21, v_len_60i = 24'd18, v_len_60p = 24'd17;
    logic          status_wr = 1'b0;
    logic [3:2]    status_wdata = 2'b00;
    logic [11:10]  irq_mask = 2'b00;
    logic hblank_start, hblank_end, vblank_start, vblank_end, in_vblank, field, disp_irq;
    logic [15:0] status;
    logic [3:0]  sys_irq;

    int n_checks = 0;
    int n_fail = 0;

    // model state
    int m_hc, m_hl, m_vc, m_vl;
    bit m_inv, m_field, m_st2, m_st3, m_arm2, m_arm3, m_disp, m_s2, m_s3;

    blank_timing_gen #(.HW(HW), .VW(VW)) uut (
        .clk(clk), .rst_n(rst_n), .sel_50hz(sel_50hz), .sel_interlace(sel_interlace),
        .h_len_50(h_len_50), .h_len_60(h_len_60),
        .v_len_50i(v_len_50i), .v_len_50p(v_len_50p), .v_len_60i(v_len_60i), .v_len_60p(v_len_60p),
        .status_wr(status_wr), .status_wdata(status_wdata), .irq_mask(irq_mask),
        .hblank_start(hblank_start), .hblank_end(hblank_end),
        .vblank_start(vblank_start), .vblank_end(vblank_end),
        .in_vblank(in_vblank), .field(field), .status(status),
        .disp_irq(disp_irq), .sys_irq(sys_irq)
    );

    always #10 clk = ~clk;

    function automatic int pick_h();
        return sel_50hz ? int'(h_len_50) : int'(h_len_60);
    endfunction

    function automatic int pick_v();
        case ({sel_50hz, sel_interlace})
            2'b11:   return int'(v_len_50i);
            2'b10:   return int'(v_len_50p);
            2'b01:   return int'(v_len_60i);
            default: return int'(v_len_60p);
        endcase
    endfunction

    function automatic logic [15:0] exp_status();
        logic [15:0] s = '0;
        s[2] = m_st2; s[3] = m_st3; s[13] = m_field;
        return s;
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare all outputs with the model (called between edges).
    task automatic check_all();
        bit he, ve;
        he = (m_hc == m_hl / 2);
        ve = (m_vc == m_vl / 2) && m_inv;
        check("R1 R10 hblank_start", 16'(hblank_start), 16'(m_hc == 0));
        check("R2 hblank_end", 16'(hblank_end), 16'(he));
        check("R3 vblank_start", 16'(vblank_start), 16'(m_vc == 0));
        check("R4 vblank_end", 16'(vblank_end), 16'(ve));
        check("R4 in_vblank", 16'(in_vblank), 16'(m_inv));
        check("R5 field", 16'(field), 16'(m_field));
        check("R6 R7 status", status, exp_status());
        check("R8 disp_irq", 16'(disp_irq), 16'(m_disp));
        check("R9 sys_irq", 16'(sys_irq), {12'h0, m_s3, m_s2, 2'b00});
    endtask

    // Advance the model across one rising edge with the inputs now applied.
    task automatic model_step();
        bit hs, he, vs, ve, ch, cv;
        if (!rst_n) begin
            m_hc = 0; m_hl = pick_h(); m_vc = 0; m_vl = pick_v();
            m_inv = 0; m_field = 0; m_st2 = 0; m_st3 = 0; m_arm2 = 1; m_arm3 = 1;
            m_disp = 0; m_s2 = 0; m_s3 = 0;
            return;
        end
        hs = (m_hc == 0);
        he = (m_hc == m_hl / 2);
        vs = (m_vc == 0);
        ve = (m_vc == m_vl / 2) && m_inv;
        ch = status_wr && status_wdata[2];
        cv = status_wr && status_wdata[3];
        m_disp = (he && m_arm2 && !irq_mask[10]) || (ve && m_arm3 && !irq_mask[11]);
        m_s2 = vs;
        m_s3 = ve;
        if (he) begin m_st2 = 1; m_arm2 = 0; end
        else if (ch) begin m_st2 = 0; m_arm2 = 1; end
        if (ve) begin m_st3 = 1; m_arm3 = 0; end
        else if (cv) begin m_st3 = 0; m_arm3 = 1; end
        if (vs) m_inv = 1; else if (ve) m_inv = 0;
        if (ve) m_field = !m_field;
        if (m_hc == m_hl - 1) begin m_hc = 0; m_hl = pick_h(); end else m_hc++;
        if (m_vc == m_vl - 1) begin m_vc = 0; m_vl = pick_v(); end else m_vc++;
        if (hs && m_hl < 0) m_hl = 0; // keeps hs used; never taken
    endtask

    // One cycle: check, drive, model, wait for the edge.
    task automatic cycle(input bit do_check);
        @(negedge clk);
        if (do_check) check_all();
    endtask

    task automatic apply_and_step();
        model_step();
        @(posedge clk);
    endtask

    task automatic rand_inputs(input int k);
        if (($urandom % 97) == 0) begin
            h_len_50 = 16'(2 + $urandom % 11);
            h_len_60 = 16'(2 + $urandom % 11);
            v_len_50i = 24'(4 + $urandom % 57);
            v_len_50p = 24'(4 + $urandom % 57);
            v_len_60i = 24'(4 + $urandom % 57);
            v_len_60p = 24'(4 + $urandom % 57);
        end
        if (($urandom % 61) == 0) sel_50hz = 1'($urandom);
        if (($urandom % 67) == 0) sel_interlace = 1'($urandom);
        if (($urandom % 40) == 0) irq_mask = 2'($urandom);
        status_wr = (($urandom % 6) == 0);
        status_wdata = 2'($urandom);
        rst_n = !(k > 0 && (k % 7001) == 0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd20240611));
        // reset for two cycles
        rst_n = 1'b0;
        repeat (2) begin
            @(negedge clk);
            model_step();
            @(posedge clk);
        end
        @(negedge clk);
        // R11: reset state at the ports
        check("R11 status after reset", status, 16'h0);
        check("R11 disp_irq after reset", 16'(disp_irq), 16'h0);
        check("R11 sys_irq after reset", 16'(sys_irq), 16'h0);
        check("R11 in_vblank after reset", 16'(in_vblank), 16'h0);
        check_all();
        rst_n = 1'b1;
        apply_and_step();

        // directed: masked horizontal event consumes the arm (R8), then a clear re-arms (R7)
        irq_mask = 2'b01; // bit 10 set
        for (int k = 0; k < 40; k++) begin
            cycle(1'b1);
            status_wr = 1'b0;
            apply_and_step();
        end
        irq_mask = 2'b00;
        for (int k = 0; k < 20; k++) begin
            cycle(1'b1);
            apply_and_step();
        end
        check("R8 no irq while disarmed", 16'(m_arm2), 16'h0);
        cycle(1'b1);
        status_wr = 1'b1; status_wdata = 2'b11;
        apply_and_step();
        cycle(1'b1);
        status_wr = 1'b0;
        apply_and_step();
        check("R7 re-armed by clear", 16'(m_arm2 | m_st2), 16'h1);

        // random phase
        for (int k = 0; k < STEPS; k++) begin
            cycle(1'b1);
            rand_inputs(k);
            apply_and_step();
        end
        @(negedge clk);
        check_all();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule